// File: doc/BRIEF.md
# Iterative Integer Divider with Zero-Divisor Trap

This block computes the quotient of two integers, either as unsigned values or as two's-complement values, over a fixed number of clock cycles. A caller presents a dividend, a divisor and a mode bit, and raises `start` for one cycle. The block then runs one restoring shift-subtract step per clock. When the quotient is ready it presents it together with a one-cycle `done` pulse. The quotient stays on the output until the next division completes.

A zero divisor skips the iteration entirely. The block returns a zero quotient at once, sets a sticky divide-by-zero status bit and, when traps are enabled and not masked by configuration, raises a trap request carrying a fixed cause code. Any division with a nonzero divisor clears the status bit when it completes. A `start` that arrives while a division is in progress is dropped.

Top module: `int_divider`

## Requirements
- R1: Unsigned mode (`signed_mode`=0) gives the floor of dividend / divisor. `done` is high for exactly one cycle. For a nonzero divisor it rises at the W+1-th rising clock edge, counting the edge that accepts `start` as the first edge (the 33rd edge for W=32). `quotient` keeps its value until the next completion.
- R2: Signed mode (`signed_mode`=1) treats both operands as two's complement and truncates the quotient toward zero (for example -7 / 2 = -3).
- R3: In signed mode, the most negative value divided by -1 returns the most negative value.
- R4: A zero divisor gives `quotient` = 0, and `done` rises at the edge that accepts `start`.
- R5: A completion with a zero divisor sets `dz_flag` to 1. The flag holds until the next completion.
- R6: A completion with a nonzero divisor clears `dz_flag` to 0, in the same cycle that `done` rises.
- R7: `trap_req` pulses together with `done` only for a zero divisor, and only when `trap_enable`=1 and `trap_mask`=0 at the accepting edge. In every other case it stays 0.
- R8: `trap_cause` equals the divide-by-zero code (5, default `CAUSE_DIVZERO`) while `trap_req` is high, and 0 otherwise.
- R9: A `start` received while a division is in progress is ignored. The running division finishes with its own operands and its own timing.
- R10: After reset, `quotient`, `done`, `dz_flag`, `trap_req` and `trap_cause` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division; sampled only when idle |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | W | Numerator |
| divisor | input | W | Denominator |
| trap_enable | input | 1 | Global trap enable |
| trap_mask | input | 1 | Configuration bit that suppresses the divide trap |
| quotient | output | W | Result of the last completed division |
| done | output | 1 | One-cycle completion pulse |
| dz_flag | output | 1 | Sticky divide-by-zero status |
| trap_req | output | 1 | Trap request pulse |
| trap_cause | output | CAUSE_W | Cause code accompanying trap_req |

## Verification
The bench builds the divider with its defaults: W=32, a 5-bit cause field and cause code 5. At full 32-bit width the sign-boundary operands are reachable: 0x80000000 divided by -1 and by 2, 0xFFFFFFFF as an unsigned dividend, and a signed/unsigned reading of the same bit patterns. The 32-step latency is also measured edge by edge. Zero-divisor cases cover every combination of trap enable and trap mask. Status clearing is checked by a nonzero division that follows a zero one, and a second start is injected mid-run to show that it is dropped.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;

    localparam int          DEF_WIDTH     = 32;
    localparam int          DEF_CAUSE_W   = 5;
    localparam logic [4:0]  DEF_DZ_CAUSE  = 5'd5;

    // Outcome handed from the sequencer to the status block at completion.
    typedef struct packed {
        logic fin;
        logic zero_div;
    } div_outcome_t;

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
    parameter int W = div_pkg::DEF_WIDTH
) (
    input  logic         signed_mode,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic [W-1:0] num_mag,
    output logic [W-1:0] den_mag,
    output logic         flip_sign,
    output logic         den_zero
);
    logic num_neg;
    logic den_neg;

    always_comb begin
        num_neg   = signed_mode & num[W-1];
        den_neg   = signed_mode & den[W-1];
        num_mag   = num_neg ? (~num + {{(W-1){1'b0}}, 1'b1}) : num;
        den_mag   = den_neg ? (~den + {{(W-1){1'b0}}, 1'b1}) : den;
        flip_sign = num_neg ^ den_neg;
        den_zero  = (den == '0);
    end
endmodule

// File: rtl/div_core.sv
module div_core #(
    parameter int W = div_pkg::DEF_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] num_in,
    input  logic [W-1:0] den_in,
    output logic [W-1:0] quo_next
);
    logic [W-1:0] part_q;
    logic [W-1:0] work_q;
    logic [W-1:0] den_q;
    logic [W:0]   shifted;
    logic [W:0]   trial;
    logic [W-1:0] part_next;

    // One restoring step: shift in the next numerator bit, try a subtract.
    always_comb begin
        shifted = {part_q, work_q[W-1]};
        trial   = shifted - {1'b0, den_q};
        if (!trial[W]) begin
            part_next = trial[W-1:0];
            quo_next  = {work_q[W-2:0], 1'b1};
        end else begin
            part_next = shifted[W-1:0];
            quo_next  = {work_q[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            part_q <= '0;
            work_q <= '0;
            den_q  <= '0;
        end else if (load) begin
            part_q <= '0;
            work_q <= num_in;
            den_q  <= den_in;
        end else if (step) begin
            part_q <= part_next;
            work_q <= quo_next;
        end
    end
endmodule

// File: rtl/div_status.sv
module div_status #(
    parameter int                 CAUSE_W       = div_pkg::DEF_CAUSE_W,
    parameter logic [CAUSE_W-1:0] CAUSE_DIVZERO = CAUSE_W'(div_pkg::DEF_DZ_CAUSE)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  div_pkg::div_outcome_t outcome,
    input  logic                  trap_enable,
    input  logic                  trap_mask,
    output logic                  dz_flag,
    output logic                  trap_req,
    output logic [CAUSE_W-1:0]    trap_cause
);
    logic raise;

    always_comb raise = outcome.fin & outcome.zero_div & trap_enable & ~trap_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            dz_flag    <= 1'b0;
            trap_req   <= 1'b0;
            trap_cause <= '0;
        end else begin
            if (outcome.fin)
                dz_flag <= outcome.zero_div;
            trap_req   <= raise;
            trap_cause <= raise ? CAUSE_DIVZERO : '0;
        end
    end

    // R5
    dz_set_chk: assert property (@(posedge clk) disable iff (rst)
        (outcome.fin && outcome.zero_div) |=> dz_flag);

    // R6
    dz_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (outcome.fin && !outcome.zero_div) |=> !dz_flag);

    // R7
    trap_gate_chk: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> $past(outcome.fin && outcome.zero_div && trap_enable && !trap_mask));

    // R8
    trap_cause_chk: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> (trap_cause == CAUSE_DIVZERO));
endmodule

// File: rtl/int_divider.sv
module int_divider #(
    parameter int                 W             = div_pkg::DEF_WIDTH,
    parameter int                 CAUSE_W       = div_pkg::DEF_CAUSE_W,
    parameter logic [CAUSE_W-1:0] CAUSE_DIVZERO = CAUSE_W'(div_pkg::DEF_DZ_CAUSE)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               signed_mode,
    input  logic [W-1:0]       dividend,
    input  logic [W-1:0]       divisor,
    input  logic               trap_enable,
    input  logic               trap_mask,
    output logic [W-1:0]       quotient,
    output logic               done,
    output logic               dz_flag,
    output logic               trap_req,
    output logic [CAUSE_W-1:0] trap_cause
);
    import div_pkg::*;

    localparam int              CNT_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    div_state_e     state_q;
    logic [CNT_W-1:0] cnt_q;
    logic           flip_q;
    logic [W-1:0]   num_mag;
    logic [W-1:0]   den_mag;
    logic           flip_sign;
    logic           den_zero;
    logic [W-1:0]   quo_next;
    logic           accept;
    logic           load;
    logic           step;
    logic           last_step;
    logic [W-1:0]   signed_quo;
    div_outcome_t   outcome;

    div_operand_prep #(.W(W)) u_prep (
        .signed_mode (signed_mode),
        .num         (dividend),
        .den         (divisor),
        .num_mag     (num_mag),
        .den_mag     (den_mag),
        .flip_sign   (flip_sign),
        .den_zero    (den_zero)
    );

    div_core #(.W(W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .step     (step),
        .num_in   (num_mag),
        .den_in   (den_mag),
        .quo_next (quo_next)
    );

    always_comb begin
        accept     = (state_q == ST_IDLE) && start;
        load       = accept && !den_zero;
        step       = (state_q == ST_RUN);
        last_step  = step && (cnt_q == LAST);
        signed_quo = flip_q ? (~quo_next + {{(W-1){1'b0}}, 1'b1}) : quo_next;
        outcome.fin      = (accept && den_zero) || last_step;
        outcome.zero_div = accept && den_zero;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            flip_q   <= 1'b0;
            quotient <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (den_zero) begin
                            quotient <= '0;
                            done     <= 1'b1;
                        end else begin
                            state_q <= ST_RUN;
                            cnt_q   <= '0;
                            flip_q  <= flip_sign;
                        end
                    end
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (last_step) begin
                        quotient <= signed_quo;
                        done     <= 1'b1;
                        state_q  <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    div_status #(.CAUSE_W(CAUSE_W), .CAUSE_DIVZERO(CAUSE_DIVZERO)) u_status (
        .clk         (clk),
        .rst         (rst),
        .outcome     (outcome),
        .trap_enable (trap_enable),
        .trap_mask   (trap_mask),
        .dz_flag     (dz_flag),
        .trap_req    (trap_req),
        .trap_cause  (trap_cause)
    );

    // R4
    zero_quick_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && start && divisor == '0) |=> (done && quotient == '0));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && cnt_q != LAST) |=> (state_q == ST_RUN && !done));

    // R1
    done_source_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(outcome.fin));

    // R1
    quo_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(quotient));
endmodule

// File: tb/int_divider_bench.sv
module int_divider_bench;
    localparam int W  = 32;
    localparam int CW = 5;
    localparam int NV = 11;

    // {signed_mode, dividend, divisor, expected quotient}
    localparam logic [3*W:0] VEC [NV] = '{
        {1'b0, 32'd100,        32'd7,          32'd14},
        {1'b0, 32'hFFFFFFFF,   32'd1,          32'hFFFFFFFF},
        {1'b0, 32'd5,          32'd9,          32'd0},
        {1'b0, 32'hFFFFFFFF,   32'h10,         32'h0FFFFFFF},
        {1'b0, 32'd1000000,    32'd1000,       32'd1000},
        {1'b0, 32'h80000000,   32'hFFFFFFFF,   32'd0},
        {1'b1, 32'hFFFFFFF9,   32'd2,          32'hFFFFFFFD},
        {1'b1, 32'd7,          32'hFFFFFFFE,   32'hFFFFFFFD},
        {1'b1, 32'hFFFFFFF9,   32'hFFFFFFFE,   32'd3},
        {1'b1, 32'h80000000,   32'd2,          32'hC0000000},
        {1'b1, 32'h80000000,   32'hFFFFFFFF,   32'h80000000}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          signed_mode = 1'b0;
    logic [W-1:0]  dividend = '0;
    logic [W-1:0]  divisor = '0;
    logic          trap_enable = 1'b0;
    logic          trap_mask = 1'b0;
    logic [W-1:0]  quotient;
    logic          done;
    logic          dz_flag;
    logic          trap_req;
    logic [CW-1:0] trap_cause;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    logic [W-1:0]  r_quo;
    logic          r_dz;
    logic          r_trap;
    logic [CW-1:0] r_cause;
    int            r_edges;

    always #5 clk = ~clk;

    int_divider u_int_divider (
        .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode),
        .dividend(dividend), .divisor(divisor), .trap_enable(trap_enable),
        .trap_mask(trap_mask), .quotient(quotient), .done(done),
        .dz_flag(dz_flag), .trap_req(trap_req), .trap_cause(trap_cause)
    );

    task automatic check(input logic ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one division; optionally injects a second start mid-run.
    task automatic run_div(input logic sm, input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic en, input logic msk, input logic inject);
        @(negedge clk);
        signed_mode = sm; dividend = a; divisor = b;
        trap_enable = en; trap_mask = msk; start = 1'b1;
        @(posedge clk);
        r_edges = 1;
        @(negedge clk);
        start = 1'b0;
        while (!done && r_edges < 100) begin
            if (inject && r_edges == 10) begin
                start = 1'b1; divisor = '0; dividend = 32'd9;
                signed_mode = 1'b0; trap_enable = 1'b1; trap_mask = 1'b0;
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            r_edges++;
            @(negedge clk);
        end
        start   = 1'b0;
        r_quo   = quotient;
        r_dz    = dz_flag;
        r_trap  = trap_req;
        r_cause = trap_cause;
        @(posedge clk);
        @(negedge clk);
        // R1: done lasts a single cycle
        check(done == 1'b0, "R1 done width", W'(done), '0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        check(quotient == '0 && !done && !dz_flag && !trap_req && trap_cause == '0,
              "R10 reset", quotient, '0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            run_div(VEC[i][3*W], VEC[i][3*W-1:2*W], VEC[i][2*W-1:W], 1'b1, 1'b0, 1'b0);
            // R1 R2 R3: quotient value by mode
            check(r_quo == VEC[i][W-1:0], VEC[i][3*W] ? "R2/R3 signed quotient" : "R1 unsigned quotient",
                  r_quo, VEC[i][W-1:0]);
            // R1: latency
            check(r_edges == W + 1, "R1 latency", W'(r_edges), W'(W + 1));
            // R7: no trap for nonzero divisor
            check(!r_trap && r_cause == '0, "R7 no trap nonzero", W'(r_trap), '0);
        end

        // R4 R5 R7 R8: zero divisor with traps enabled
        run_div(1'b0, 32'd77, '0, 1'b1, 1'b0, 1'b0);
        check(r_quo == '0, "R4 zero quotient", r_quo, '0);
        check(r_edges == 1, "R4 early finish", W'(r_edges), W'(1));
        check(r_dz == 1'b1, "R5 dz set", W'(r_dz), W'(1));
        check(r_trap == 1'b1, "R7 trap raised", W'(r_trap), W'(1));
        check(r_cause == 5'd5, "R8 cause code", W'(r_cause), W'(5));
        // R8: cause clears after the pulse
        check(trap_cause == '0 && !trap_req, "R8 cause idle", W'(trap_cause), '0);
        // R5: flag sticky while idle
        repeat (4) @(negedge clk);
        check(dz_flag == 1'b1, "R5 dz sticky", W'(dz_flag), W'(1));

        // R6: nonzero completion clears dz
        run_div(1'b1, 32'd40, 32'd8, 1'b1, 1'b0, 1'b0);
        check(r_dz == 1'b0, "R6 dz cleared", W'(r_dz), '0);
        check(r_quo == 32'd5, "R6 quotient", r_quo, 32'd5);

        // R7: traps disabled
        run_div(1'b1, 32'hFFFFFFF0, '0, 1'b0, 1'b0, 1'b0);
        check(!r_trap && r_cause == '0, "R7 disabled", W'(r_trap), '0);
        check(r_dz == 1'b1 && r_quo == '0, "R5 dz disabled", W'(r_dz), W'(1));

        // R7: trap masked by configuration
        run_div(1'b0, 32'd3, '0, 1'b1, 1'b1, 1'b0);
        check(!r_trap && r_cause == '0, "R7 masked", W'(r_trap), '0);
        check(r_dz == 1'b1, "R5 dz masked", W'(r_dz), W'(1));

        // R9: second start mid-run is dropped
        run_div(1'b0, 32'd100, 32'd7, 1'b1, 1'b0, 1'b1);
        check(r_quo == 32'd14, "R9 busy quotient", r_quo, 32'd14);
        check(r_edges == W + 1, "R9 busy latency", W'(r_edges), W'(W + 1));
        check(!r_dz && !r_trap, "R9 busy status", W'({r_dz, r_trap}), '0);
        repeat (3) @(negedge clk);
        check(!done && quotient == 32'd14, "R9 no late result", quotient, 32'd14);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=<100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule